// File: doc/BRIEF.md
# Registered Byte ROM with Selectable Enable Timing

This block is a byte-wide read-only store. Its read data always passes through an edge-triggered output register, so the word at the address presented before a rising clock edge appears on the output pins after that edge. The address needs no hold time after the edge. A new address may be driven right after the edge without disturbing the word that was just captured.

A single active-low enable pin gates the outputs. A stored mode bit, loaded from bit 0 of a configuration byte, decides how that pin acts. When the bit is 0, which is the erased default, the pin drives the output buffers combinationally. When the bit is 1, the pin is sampled at each rising edge and the drive state changes only after that edge. Tri-state outputs are modelled as a data bus plus a drive flag, and the data bus reads as zero whenever the flag is low. A preload stream port fills the array. It follows a valid/ready handshake, but ready is held high, so it never applies back-pressure and every beat with valid high is written at that clock edge.

Top module: `rrom_top`

## Requirements
- R1: While reset is held and just after it, `rd_drive` is 0, `rd_data` is 0, and the enable mode is combinational (mode bit 0).
- R2: The word stored at `addr` at a rising edge appears on `rd_data` after that edge. It stays there until the next edge, even if `addr` changes 1 ns after the edge.
- R3: A preload beat with `pl_valid` high and `pl_ready` high writes `pl_data` at `pl_addr` at the rising edge. A read of the same address at that same edge returns the old word, and reads at later edges return the new word. `pl_ready` is always 1.
- R4: When `cfg_we` is high at a rising edge, bit 0 of `cfg_byte` becomes the mode bit: 0 selects combinational enable and 1 selects clocked enable. The other seven bits have no effect.
- R5: In combinational mode, once the outputs have been primed, `rd_drive` equals the inverse of `en_n` at all times. Raising `en_n` between edges drops the drive at once, and lowering it restores the held word without a clock edge.
- R6: In clocked mode, `rd_drive` after an edge equals the inverse of `en_n` sampled at that edge. A toggle of `en_n` between edges has no effect.
- R7: An edge with `en_n` high still loads the output register, so a later enable shows the word captured at that disabled edge.
- R8: Whenever `rd_drive` is 0, `rd_data` reads as 0.
- R9: After reset, the outputs stay undriven in both modes until the first rising edge at which `en_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Read address, sampled at the rising edge |
| en_n | input | 1 | Active-low output enable |
| cfg_we | input | 1 | Load strobe for the configuration byte |
| cfg_byte | input | 8 | Configuration byte; bit 0 selects the enable mode |
| pl_valid | input | 1 | Preload beat valid |
| pl_ready | output | 1 | Preload ready, always 1 |
| pl_addr | input | ADDR_W | Preload write address |
| pl_data | input | DATA_W | Preload write data |
| rd_data | output | DATA_W | Registered read data, zero when undriven |
| rd_drive | output | 1 | Output drive flag (low means high impedance) |

## Verification
Read data is due one rising edge after the address is presented. The bench moves the address 1 ns after each edge and checks the word 4 ns later, well before the next edge. In clocked mode the drive flag is due after the edge that samples `en_n`. In combinational mode it is due with no edge at all, so the bench toggles `en_n` in mid-cycle and samples 1 ns later. The expected behaviour in that window differs by mode. A preload write is checked at two points: at the edge of the write the read still returns the old word, and one edge later it returns the new word.

// File: rtl/rrom_pkg.sv
package rrom_pkg;
  typedef enum logic {
    OE_COMB = 1'b0,
    OE_CLKD = 1'b1
  } oe_mode_e;

  localparam int CFG_W    = 8;
  localparam int MODE_BIT = 0;
endpackage

// File: rtl/rrom_array.sv
module rrom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // preload port: plain synchronous write
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // output register: loads on every edge, whether or not the enable is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/rrom_cfg.sv
module rrom_cfg
  import rrom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_byte,
  output oe_mode_e         mode
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mode <= OE_COMB;
    else if (cfg_we) mode <= oe_mode_e'(cfg_byte[MODE_BIT]);
  end
endmodule

// File: rtl/rrom_oe.sv
module rrom_oe
  import rrom_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_n,
  input  oe_mode_e mode,
  output logic     drive
);
  logic oe_q;    // enable sampled at the edge (clocked mode)
  logic primed;  // set by the first enabled edge after reset

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      primed <= 1'b0;
    end else begin
      oe_q <= ~en_n;
      if (!en_n) primed <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      OE_CLKD: drive = oe_q;
      default: drive = primed & ~en_n;
    endcase
  end
endmodule

// File: rtl/rrom_top.sv
module rrom_top
  import rrom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_byte,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  oe_mode_e          mode;
  logic              mode_clkd;
  logic [DATA_W-1:0] rd_q;
  logic              drive;

  assign pl_ready  = 1'b1;
  assign mode_clkd = (mode == OE_CLKD);

  rrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pl_valid & pl_ready),
    .wr_addr (pl_addr),
    .wr_data (pl_data),
    .rd_addr (addr),
    .rd_q    (rd_q)
  );

  rrom_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_byte (cfg_byte),
    .mode     (mode)
  );

  rrom_oe u_oe (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (en_n),
    .mode  (mode),
    .drive (drive)
  );

  assign rd_drive = drive;
  assign rd_data  = drive ? rd_q : '0;
endmodule

// File: rtl/rrom_chk.sv
module rrom_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_byte,
  input logic              mode_clkd,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive
);
  // R8
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == '0);

  // R6
  clkd_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_clkd && !cfg_we && !en_n) |=> rd_drive);

  // R6
  clkd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_clkd && !cfg_we && en_n) |=> !rd_drive);

  // R5
  comb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_clkd && en_n) |-> !rd_drive);

  // R4
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> mode_clkd == $past(cfg_byte[0]));
endmodule

bind rrom_top rrom_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_n      (en_n),
  .cfg_we    (cfg_we),
  .cfg_byte  (cfg_byte),
  .mode_clkd (mode_clkd),
  .rd_data   (rd_data),
  .rd_drive  (rd_drive)
);

// File: tb/tb_rrom_top.sv
module tb_rrom_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          en_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_byte = '0;
  logic          pl_valid = 1'b0;
  logic          pl_ready;
  logic [AW-1:0] pl_addr = '0;
  logic [DW-1:0] pl_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int total = 0;
  int bad = 0;

  rrom_top #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_load(input logic [7:0] b);
    @(negedge clk); cfg_byte = b; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // sweep every address; mid-cycle enable toggles on some of them
  task automatic sweep(input bit clkd);
    @(negedge clk); addr = '0; en_n = 1'b0;
    for (int a = 0; a < N; a++) begin
      @(posedge clk); #1 addr = AW'(a + 1);
      #3;
      chk(rd_drive && rd_data == pat(a), "R2", rd_data, pat(a));
      if (a % 8 == 3) begin
        en_n = 1'b1; #1;
        if (clkd) chk(rd_drive == 1'b1, "R6", rd_drive, 1);
        else      chk(rd_drive == 1'b0 && rd_data == '0, "R5", rd_drive, 0);
        en_n = 1'b0; #1;
        chk(rd_drive && rd_data == pat(a), clkd ? "R6" : "R5", rd_data, pat(a));
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_drive == 1'b0 && rd_data == '0, "R1", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_drive == 1'b0 && rd_data == '0, "R1", rd_drive, 0);
    chk(pl_ready == 1'b1, "R3", pl_ready, 1);

    // preload all words with en_n held high
    for (int a = 0; a < N; a++) begin
      pl_valid = 1'b1; pl_addr = AW'(a); pl_data = pat(a);
      @(negedge clk);
    end
    pl_valid = 1'b0;

    // R9: enable low but no enabled edge yet
    en_n = 1'b0; #1;
    chk(rd_drive == 1'b0, "R9", rd_drive, 0);
    @(posedge clk); #2;
    chk(rd_drive == 1'b1, "R9", rd_drive, 1);
    // mode is combinational after reset (R1): mid-cycle raise drops drive
    en_n = 1'b1; #1;
    chk(rd_drive == 1'b0, "R1", rd_drive, 0);
    en_n = 1'b0;

    sweep(1'b0);

    // R7: disabled edge still captures
    @(negedge clk); addr = AW'(77); en_n = 1'b1;
    @(posedge clk); #2;
    chk(rd_drive == 1'b0 && rd_data == '0, "R8", rd_data, 0);
    en_n = 1'b0; #1;
    chk(rd_data == pat(77), "R7", rd_data, pat(77));

    // R4: upper bits ignored, bit 0 = 0 keeps combinational mode
    cfg_load(8'hFE);
    #5 en_n = 1'b1; #1;
    chk(rd_drive == 1'b0, "R4", rd_drive, 0);
    en_n = 1'b0;
    cfg_load(8'h01);
    #5 en_n = 1'b1; #1;
    chk(rd_drive == 1'b1, "R4", rd_drive, 1);
    en_n = 1'b0;

    sweep(1'b1);

    // R6: enable sampled at the edge in clocked mode
    @(negedge clk); en_n = 1'b1; addr = AW'(9);
    @(posedge clk); #2;
    chk(rd_drive == 1'b0 && rd_data == '0, "R6", rd_drive, 0);
    en_n = 1'b0; #3;
    chk(rd_drive == 1'b0, "R6", rd_drive, 0);
    @(posedge clk); #2;
    chk(rd_drive == 1'b1 && rd_data == pat(9), "R6", rd_data, pat(9));

    // R3: write and read the same address at the same edge
    @(negedge clk); addr = AW'(5); pl_valid = 1'b1; pl_addr = AW'(5); pl_data = 8'hA5;
    @(posedge clk); #2;
    pl_valid = 1'b0;
    chk(rd_data == pat(5), "R3", rd_data, pat(5));
    @(posedge clk); #2;
    chk(rd_data == 8'hA5, "R3", rd_data, 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule